// File: doc/BRIEF.md
# Pipelined Priority Bus Arbiter

This block decides which of several bus masters owns the address phase of a shared system bus. Address and data phases are handled apart: a master starts its address tenure as soon as it holds the grant, while its data tenure may finish many cycles later. The arbiter counts the address tenures whose data has not yet completed, and it refuses new grants once that count reaches a programmable pipeline depth of one to four. Each data transfer is a 32-byte burst, one cache line, so a single completion pulse retires one tenure.

Each master drives a request and a two-bit priority. The highest priority wins, and equal-priority masters take turns in round-robin order. An optional repeat mode lets the current owner keep the bus for a programmable run of consecutive tenures. When the idle address bus has no requester, a parking policy chooses who holds the grant: nobody, the last owner, or a master picked by software. A small write-only register port sets the depth, the repeat mode and the parking policy.

The grant is a combinational function of the requests and the registered state. An address tenure starts in any cycle where a granted master also requests. A parked master that raises its request therefore starts in that same cycle.

Top module: `pipe_prio_arb`

## Requirements
- R1: After reset `gnt_o` and `outstanding_o` are zero, the pipeline depth is 4, repeat mode is off and parking is disabled.
- R2: With repeat mode off, the grant goes to a requester whose priority is the highest among the requests. Master i's priority is `prio_i[2i+1:2i]`, and 3 is the highest level. At most one grant bit is set.
- R3: Among requesters at the winning level, the grant goes to the first requester after the master last granted at that level, in ascending index order with wrap-around.
- R4: `start_o` is high in a cycle where a granted master requests. On the next edge `outstanding_o` rises by one for a start without `data_done_i`, falls by one for `data_done_i` without a start, and holds when both or neither occur.
- R5: A write to address 0 sets the depth to `cfg_wdata_i[1:0]`+1. While `outstanding_o` is at or above the depth, `gnt_o` is zero.
- R6: A write to address 1 sets repeat enable from bit 0 and the run limit from bits [3:1]+1. With repeat enabled, the last owner keeps the grant while it requests and its consecutive tenure count is below the limit, even against higher-priority requests.
- R7: With repeat enabled and the owner's consecutive count at the limit, the owner is passed over if any other master requests. If no other master requests, the owner is granted again and its count restarts at one.
- R8: A write to address 2 sets the park mode from bits [1:0]. In mode 0 or 3 with no requests, `gnt_o` is zero.
- R9: In park mode 1 with no requests, `gnt_o` selects the master that started the most recent tenure.
- R10: In park mode 2 with no requests, `gnt_o` selects the master given by bits [5:4] of the address-2 write. If that master raises its request, `start_o` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Address tenure request per master |
| prio_i | input | 8 | Two-bit priority per master |
| data_done_i | input | 1 | Completion pulse of the oldest data tenure |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 6 | Configuration write data |
| gnt_o | output | 4 | One-hot address bus grant |
| start_o | output | 1 | Address tenure starts this cycle |
| outstanding_o | output | 3 | Address tenures whose data is not yet complete |

## Verification
The assertions assume that `data_done_i` is never pulsed while `outstanding_o` is zero, because a completion with nothing outstanding has no meaning for the counter. They also assume that the configuration is written only while no tenure starts. The bench pulses the completion only in the same cycle as a start or while tenures are pending, and it performs every register write with all requests low. The priority check applies only while repeat mode is off, and the hold and skip checks follow the owner's run length from the grant and start ports alone.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam logic [1:0] CFG_PIPE = 2'd0;
  localparam logic [1:0] CFG_RPT  = 2'd1;
  localparam logic [1:0] CFG_PARK = 2'd2;
  localparam int PARK_IDX_LSB = 4;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_pkg::*;
#(
  parameter int N_MST     = 4,
  parameter int MAX_DEPTH = 4,
  parameter int MAX_RPT   = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [1:0]                           addr_i,
  input  logic [PARK_IDX_LSB+$clog2(N_MST)-1:0] wdata_i,
  output logic [$clog2(MAX_DEPTH+1)-1:0]       depth_o,
  output logic                                 rpt_en_o,
  output logic [$clog2(MAX_RPT+1)-1:0]         rpt_lim_o,
  output park_mode_e                           park_mode_o,
  output logic [$clog2(N_MST)-1:0]             park_idx_o
);
  localparam int IW  = $clog2(N_MST);
  localparam int DCW = $clog2(MAX_DEPTH + 1);
  localparam int RCW = $clog2(MAX_RPT + 1);
  localparam int DFW = $clog2(MAX_DEPTH);
  localparam int RFW = $clog2(MAX_RPT);

  logic [DCW-1:0] depth_wr;
  logic [RCW-1:0] lim_wr;

  always_comb begin
    depth_wr = DCW'(wdata_i[DFW-1:0]) + DCW'(1);
    if (depth_wr > DCW'(MAX_DEPTH)) depth_wr = DCW'(MAX_DEPTH);
    lim_wr = RCW'(wdata_i[RFW:1]) + RCW'(1);
    if (lim_wr > RCW'(MAX_RPT)) lim_wr = RCW'(MAX_RPT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_o     <= DCW'(MAX_DEPTH);
      rpt_en_o    <= 1'b0;
      rpt_lim_o   <= RCW'(MAX_RPT);
      park_mode_o <= PARK_NONE;
      park_idx_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        CFG_PIPE: depth_o <= depth_wr;
        CFG_RPT: begin
          rpt_en_o  <= wdata_i[0];
          rpt_lim_o <= lim_wr;
        end
        CFG_PARK: begin
          park_mode_o <= park_mode_e'(wdata_i[1:0]);
          park_idx_o  <= wdata_i[PARK_IDX_LSB +: IW];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/arb_picker.sv
module arb_picker #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 2
) (
  input  logic [N_MST-1:0]                            req_i,
  input  logic [N_MST*PRIO_W-1:0]                     prio_i,
  input  logic [(1<<PRIO_W)*$clog2(N_MST)-1:0]        rr_ptr_i,
  output logic                                        vld_o,
  output logic [$clog2(N_MST)-1:0]                    idx_o
);
  localparam int IW   = $clog2(N_MST);
  localparam int LVLS = 1 << PRIO_W;

  logic [LVLS-1:0][N_MST-1:0] lvl_mask;
  logic [PRIO_W-1:0]          top_lvl;
  logic [N_MST-1:0]           cand;
  logic [IW-1:0]              ptr;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    for (genvar i = 0; i < N_MST; i++) begin : g_mst
      assign lvl_mask[l][i] = req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    top_lvl = '0;
    for (int l = LVLS - 1; l >= 0; l--) begin
      if (!found && |lvl_mask[l]) begin
        found   = 1'b1;
        top_lvl = PRIO_W'(l);
      end
    end
    cand  = lvl_mask[top_lvl];
    ptr   = rr_ptr_i[top_lvl*IW +: IW];
    vld_o = 1'b0;
    idx_o = '0;
    // search starts one past the last winner of this level
    for (int k = 1; k <= N_MST; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N_MST) j = j - N_MST;
      if (!vld_o && cand[j]) begin
        vld_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_tracker.sv
module arb_tracker #(
  parameter int N_MST     = 4,
  parameter int PRIO_W    = 2,
  parameter int MAX_DEPTH = 4,
  parameter int MAX_RPT   = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  start_i,
  input  logic                                  done_i,
  input  logic [$clog2(N_MST)-1:0]              win_idx_i,
  input  logic [PRIO_W-1:0]                     win_lvl_i,
  input  logic [$clog2(MAX_RPT+1)-1:0]          rpt_lim_i,
  output logic [$clog2(MAX_DEPTH+1)-1:0]        outst_o,
  output logic [$clog2(N_MST)-1:0]              owner_o,
  output logic                                  own_vld_o,
  output logic [$clog2(MAX_RPT+1)-1:0]          run_o,
  output logic [(1<<PRIO_W)*$clog2(N_MST)-1:0]  rr_ptr_o
);
  localparam int IW   = $clog2(N_MST);
  localparam int LVLS = 1 << PRIO_W;
  localparam int RCW  = $clog2(MAX_RPT + 1);

  logic [LVLS-1:0][IW-1:0] rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst_o <= '0;
    end else if (start_i && !done_i) begin
      outst_o <= outst_o + 1'b1;
    end else if (!start_i && done_i && outst_o != '0) begin
      outst_o <= outst_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_o   <= '0;
      own_vld_o <= 1'b0;
      run_o     <= '0;
      rr_q      <= '0;
    end else if (start_i) begin
      owner_o          <= win_idx_i;
      own_vld_o        <= 1'b1;
      rr_q[win_lvl_i]  <= win_idx_i;
      // run restarts once the limit was reached
      if (own_vld_o && owner_o == win_idx_i && run_o < rpt_lim_i) run_o <= run_o + 1'b1;
      else run_o <= RCW'(1);
    end
  end

  assign rr_ptr_o = rr_q;
endmodule

// File: rtl/pipe_prio_arb.sv
module pipe_prio_arb
  import arb_pkg::*;
#(
  parameter int N_MST     = 4,
  parameter int PRIO_W    = 2,
  parameter int MAX_DEPTH = 4,
  parameter int MAX_RPT   = 8
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_MST-1:0]                       req_i,
  input  logic [N_MST*PRIO_W-1:0]                prio_i,
  input  logic                                   data_done_i,
  input  logic                                   cfg_we_i,
  input  logic [1:0]                             cfg_addr_i,
  input  logic [PARK_IDX_LSB+$clog2(N_MST)-1:0]  cfg_wdata_i,
  output logic [N_MST-1:0]                       gnt_o,
  output logic                                   start_o,
  output logic [$clog2(MAX_DEPTH+1)-1:0]         outstanding_o
);
  localparam int IW   = $clog2(N_MST);
  localparam int LVLS = 1 << PRIO_W;
  localparam int DCW  = $clog2(MAX_DEPTH + 1);
  localparam int RCW  = $clog2(MAX_RPT + 1);

  logic [DCW-1:0]       cfg_depth;
  logic                 cfg_rpt_en;
  logic [RCW-1:0]       cfg_rpt_lim;
  park_mode_e           cfg_park_mode;
  logic [IW-1:0]        cfg_park_idx;

  logic [IW-1:0]        owner;
  logic                 own_vld;
  logic [RCW-1:0]       run_cnt;
  logic [LVLS*IW-1:0]   rr_ptr;

  logic [N_MST-1:0]     owner_oh, others, req_eff;
  logic                 full, rpt_hold, rpt_skip;
  logic                 pick_vld;
  logic [IW-1:0]        pick_idx, win_idx;
  logic [PRIO_W-1:0]    win_lvl;

  arb_cfg_regs #(
    .N_MST(N_MST), .MAX_DEPTH(MAX_DEPTH), .MAX_RPT(MAX_RPT)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .depth_o    (cfg_depth),
    .rpt_en_o   (cfg_rpt_en),
    .rpt_lim_o  (cfg_rpt_lim),
    .park_mode_o(cfg_park_mode),
    .park_idx_o (cfg_park_idx)
  );

  assign owner_oh = own_vld ? (N_MST'(1) << owner) : '0;
  assign others   = req_i & ~owner_oh;
  assign full     = outstanding_o >= cfg_depth;
  assign rpt_hold = cfg_rpt_en && own_vld && req_i[owner] && (run_cnt < cfg_rpt_lim);
  assign rpt_skip = cfg_rpt_en && own_vld && (run_cnt >= cfg_rpt_lim) && |others;
  assign req_eff  = rpt_skip ? others : req_i;

  arb_picker #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
    .req_i   (req_eff),
    .prio_i  (prio_i),
    .rr_ptr_i(rr_ptr),
    .vld_o   (pick_vld),
    .idx_o   (pick_idx)
  );

  assign win_idx = rpt_hold ? owner : pick_idx;
  assign win_lvl = prio_i[win_idx*PRIO_W +: PRIO_W];

  always_comb begin
    gnt_o = '0;
    if (full) begin
      gnt_o = '0;
    end else if (rpt_hold) begin
      gnt_o = owner_oh;
    end else if (pick_vld) begin
      gnt_o = N_MST'(1) << pick_idx;
    end else begin
      case (cfg_park_mode)
        PARK_LAST:  gnt_o = owner_oh;
        PARK_FIXED: if (int'(cfg_park_idx) < N_MST) gnt_o = N_MST'(1) << cfg_park_idx;
        default:    gnt_o = '0;
      endcase
    end
  end

  assign start_o = |(gnt_o & req_i);

  arb_tracker #(
    .N_MST(N_MST), .PRIO_W(PRIO_W), .MAX_DEPTH(MAX_DEPTH), .MAX_RPT(MAX_RPT)
  ) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_o),
    .done_i   (data_done_i),
    .win_idx_i(win_idx),
    .win_lvl_i(win_lvl),
    .rpt_lim_i(cfg_rpt_lim),
    .outst_o  (outstanding_o),
    .owner_o  (owner),
    .own_vld_o(own_vld),
    .run_o    (run_cnt),
    .rr_ptr_o (rr_ptr)
  );
endmodule

// File: rtl/pipe_prio_arb_chk.sv
module pipe_prio_arb_chk
  import arb_pkg::*;
#(
  parameter int N_MST     = 4,
  parameter int PRIO_W    = 2,
  parameter int MAX_DEPTH = 4,
  parameter int MAX_RPT   = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_MST-1:0]                req_i,
  input logic [N_MST*PRIO_W-1:0]         prio_i,
  input logic                            data_done_i,
  input logic [N_MST-1:0]                gnt_o,
  input logic                            start_o,
  input logic [$clog2(MAX_DEPTH+1)-1:0]  outstanding_o,
  input logic [$clog2(MAX_DEPTH+1)-1:0]  depth_i,
  input logic                            rpt_en_i,
  input logic [$clog2(MAX_RPT+1)-1:0]    rpt_lim_i,
  input park_mode_e                      park_mode_i
);
  localparam int RCW = $clog2(MAX_RPT + 1);

  logic [PRIO_W-1:0] max_req, gnt_lvl;
  logic [N_MST-1:0]  last_oh;
  logic              last_vld;
  logic [RCW-1:0]    run_q;
  logic              full;

  assign full = outstanding_o >= depth_i;

  always_comb begin
    logic any;
    any     = 1'b0;
    max_req = '0;
    gnt_lvl = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i] && (!any || prio_i[i*PRIO_W +: PRIO_W] > max_req)) begin
        any     = 1'b1;
        max_req = prio_i[i*PRIO_W +: PRIO_W];
      end
      if (gnt_o[i]) gnt_lvl = prio_i[i*PRIO_W +: PRIO_W];
    end
  end

  // independent run-length model from the grant ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_oh  <= '0;
      last_vld <= 1'b0;
      run_q    <= '0;
    end else if (start_o) begin
      last_oh  <= gnt_o;
      last_vld <= 1'b1;
      if (last_vld && gnt_o == last_oh && run_q < rpt_lim_i) run_q <= run_q + 1'b1;
      else run_q <= RCW'(1);
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R2
  AST_PRIO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !rpt_en_i) |-> gnt_lvl == max_req); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> outstanding_o < depth_i); // R5
  AST_FULL_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> gnt_o == '0); // R5
  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !data_done_i) |=> outstanding_o == $past(outstanding_o) + 1'b1); // R4
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_o && data_done_i && outstanding_o != '0) |=> outstanding_o == $past(outstanding_o) - 1'b1); // R4
  AST_RPT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_en_i && last_vld && |(req_i & last_oh) && run_q < rpt_lim_i && !full) |-> gnt_o == last_oh); // R6
  AST_RPT_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_en_i && last_vld && run_q >= rpt_lim_i && |(req_i & ~last_oh)) |-> !(|(gnt_o & last_oh))); // R7
  AST_PARK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0 && (park_mode_i == PARK_NONE || park_mode_i == PARK_RSVD)) |-> gnt_o == '0); // R8
endmodule

bind pipe_prio_arb pipe_prio_arb_chk #(
  .N_MST(N_MST), .PRIO_W(PRIO_W), .MAX_DEPTH(MAX_DEPTH), .MAX_RPT(MAX_RPT)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .prio_i       (prio_i),
  .data_done_i  (data_done_i),
  .gnt_o        (gnt_o),
  .start_o      (start_o),
  .outstanding_o(outstanding_o),
  .depth_i      (cfg_depth),
  .rpt_en_i     (cfg_rpt_en),
  .rpt_lim_i    (cfg_rpt_lim),
  .park_mode_i  (cfg_park_mode)
);

// File: tb/pipe_prio_arb_tb_top.sv
module pipe_prio_arb_tb_top;
  localparam int CLK_T = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [7:0] prio_i = '0;
  logic       data_done_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = '0;
  logic [5:0] cfg_wdata_i = '0;
  logic [3:0] gnt_o;
  logic       start_o;
  logic [2:0] outstanding_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_T/2) clk_i = ~clk_i;

  pipe_prio_arb dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .prio_i(prio_i),
    .data_done_i(data_done_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .gnt_o(gnt_o), .start_o(start_o),
    .outstanding_o(outstanding_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drive(input logic [3:0] r, input logic d);
    req_i = r;
    data_done_i = d;
    #1;
  endtask

  task automatic grant_is(input string tag, input logic [3:0] r, input logic d,
                          input int g, input int s);
    drive(r, d);
    chk({tag, " gnt"}, int'(gnt_o), g);
    chk({tag, " start"}, int'(start_o), s);
    tick();
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [5:0] v);
    drive(4'b0000, 1'b0);
    cfg_we_i = 1'b1;
    cfg_addr_i = a;
    cfg_wdata_i = v;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic set_prio(input logic [1:0] p3, p2, p1, p0);
    prio_i = {p3, p2, p1, p0};
  endtask

  task automatic t_reset();
    chk("R1 gnt in reset", int'(gnt_o), 0);
    chk("R1 outstanding in reset", int'(outstanding_o), 0);
    @(posedge clk_i);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    drive(4'b0000, 1'b0);
    chk("R1 idle gnt park off", int'(gnt_o), 0);
    chk("R1 outstanding", int'(outstanding_o), 0);
  endtask

  task automatic t_prio();
    set_prio(2'd0, 2'd2, 2'd3, 2'd1);
    grant_is("R2 all req", 4'b1111, 1'b1, 4'b0010, 1);
    grant_is("R2 m1 absent", 4'b1101, 1'b1, 4'b0100, 1);
    grant_is("R2 m0 vs m3", 4'b1001, 1'b1, 4'b0001, 1);
    grant_is("R2 lowest alone", 4'b1000, 1'b1, 4'b1000, 1);
    chk("R4 start with done holds", int'(outstanding_o), 0);
  endtask

  task automatic t_rr();
    set_prio(2'd2, 2'd2, 2'd2, 2'd2);
    grant_is("R3 after m2", 4'b1111, 1'b1, 4'b1000, 1);
    grant_is("R3 wrap", 4'b1111, 1'b1, 4'b0001, 1);
    grant_is("R3 next", 4'b1111, 1'b1, 4'b0010, 1);
    grant_is("R3 next", 4'b1111, 1'b1, 4'b0100, 1);
  endtask

  task automatic t_depth();
    for (int k = 1; k <= 4; k++) begin
      grant_is("R4 start", 4'b0001, 1'b0, 4'b0001, 1);
      chk("R4 outstanding inc", int'(outstanding_o), k);
    end
    grant_is("R5 reset depth 4 full", 4'b0001, 1'b0, 0, 0);
    grant_is("R4 done only", 4'b0000, 1'b1, 0, 0);
    chk("R4 outstanding dec", int'(outstanding_o), 3);
    grant_is("R4 start and done", 4'b0001, 1'b1, 4'b0001, 1);
    chk("R4 outstanding hold", int'(outstanding_o), 3);
    cfg_wr(2'd0, 6'd1);
    grant_is("R5 depth 2 blocks", 4'b0001, 1'b0, 0, 0);
    grant_is("R5 drain", 4'b0000, 1'b1, 0, 0);
    grant_is("R5 drain", 4'b0000, 1'b1, 0, 0);
    chk("R5 outstanding", int'(outstanding_o), 1);
    grant_is("R5 below depth", 4'b0001, 1'b0, 4'b0001, 1);
    grant_is("R5 at depth 2", 4'b0001, 1'b0, 0, 0);
    grant_is("R5 drain", 4'b0000, 1'b1, 0, 0);
    grant_is("R5 drain", 4'b0000, 1'b1, 0, 0);
    chk("R5 drained", int'(outstanding_o), 0);
    cfg_wr(2'd0, 6'd3);
  endtask

  task automatic t_repeat();
    cfg_wr(2'd1, 6'd5);
    set_prio(2'd0, 2'd0, 2'd3, 2'd0);
    grant_is("R7 stale run restarts", 4'b0001, 1'b1, 4'b0001, 1);
    grant_is("R6 hold vs higher", 4'b0011, 1'b1, 4'b0001, 1);
    grant_is("R6 hold third", 4'b0011, 1'b1, 4'b0001, 1);
    grant_is("R7 owner skipped", 4'b0011, 1'b1, 4'b0010, 1);
    grant_is("R6 new owner holds", 4'b0011, 1'b1, 4'b0010, 1);
    grant_is("R6 alone", 4'b0010, 1'b1, 4'b0010, 1);
    grant_is("R7 alone regranted", 4'b0010, 1'b1, 4'b0010, 1);
    grant_is("R6 count restarted", 4'b0011, 1'b1, 4'b0010, 1);
    cfg_wr(2'd1, 6'd0);
    grant_is("R6 off prio wins", 4'b0011, 1'b1, 4'b0010, 1);
  endtask

  task automatic t_park();
    cfg_wr(2'd2, 6'd1);
    grant_is("R9 park last", 4'b0000, 1'b0, 4'b0010, 0);
    grant_is("R9 new owner", 4'b0100, 1'b1, 4'b0100, 1);
    grant_is("R9 park moves", 4'b0000, 1'b0, 4'b0100, 0);
    cfg_wr(2'd2, 6'h32);
    grant_is("R10 park fixed", 4'b0000, 1'b0, 4'b1000, 0);
    grant_is("R10 same cycle start", 4'b1000, 1'b1, 4'b1000, 1);
    cfg_wr(2'd2, 6'd3);
    grant_is("R8 mode 3 idle", 4'b0000, 1'b0, 0, 0);
    cfg_wr(2'd2, 6'd0);
    grant_is("R8 mode 0 idle", 4'b0000, 1'b0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_prio();
    t_rr();
    t_depth();
    t_repeat();
    t_park();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_T * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule